// File: doc/BRIEF.md
# Multi-Buffer Receive Frame Manager

This block sits behind a bit-level serial receiver and catches the frames that receiver delivers as a byte stream. Each stream is framed by a one-cycle start strobe and a one-cycle end strobe. Three frame buffers of sixteen bytes each hold finished frames until the host collects them. Each buffer carries a two-bit age code, so software always knows which stored frame arrived first. It can drain the buffers in arrival order, whatever buffer index each frame happens to occupy.

The host reaches everything through a simple register port with a one-cycle read latency. It reads the frame bytes, the per-buffer byte counts and the packed age codes. It then releases a buffer by raising and lowering that buffer's release bit in the control register. Every occupied buffer drives its own ready interrupt line. A frame that finds no buffer free is thrown away and leaves a sticky overflow flag. A control bit chooses between using only buffer 0 and using all three.

Register map (6-bit address):
- Frame bytes are at `buffer*16 + byte`, for buffers 0 to 2.
- Lengths are at 0x30 to 0x32.
- The packed age codes are at 0x34.
- The control register is at 0x35.
- The overflow flag is at 0x36.

Top module: `frame_rx_hub`

## Requirements
- R1: After a synchronous reset every age code is 0, every length reads 0, `rdy_irq` is 0, `ovf_flag` is 0, and the control register (0x35) reads 0x00, which selects single-buffer mode.
- R2: Byte k of a stored frame in buffer n reads back at address n*16+k. The value appears on `reg_rdata` one clock after the address is presented.
- R3: Register 0x34 holds the age code of buffer 0 in bits [1:0], buffer 1 in bits [3:2] and buffer 2 in bits [5:4]. Code 0 means empty. Codes 1, 2 and 3 mark the oldest, second-oldest and third-oldest stored frame, and no two occupied buffers share a code.
- R4: A completed frame goes into the lowest-index buffer that is usable. Its age code is one more than the number of buffers already occupied.
- R5: The low 5 bits of registers 0x30+n give the byte count of buffer n. A frame of more than 16 bytes keeps its first 16 bytes and reports a length of 16.
- R6: `rdy_irq[n]` is high exactly while buffer n holds a frame that has not been released.
- R7: Writing the control register so that bit n goes from 0 to 1 releases buffer n. Its code and length become 0, its interrupt drops, and every larger age code drops by one. While bit n stays 1, buffer n receives no frame. Once bit n is written back to 0, the buffer is usable again.
- R8: Control bit 3 set makes all three buffers usable; with it clear only buffer 0 receives frames. Writing 0x0F releases every buffer and leaves bit 3 set.
- R9: A frame that starts while no buffer is usable is discarded without touching any buffer. It sets `ovf_flag`, which also reads as bit 0 of register 0x36, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_start | input | 1 | One-cycle strobe opening a frame |
| fr_valid | input | 1 | `fr_byte` carries a frame byte this cycle |
| fr_byte | input | 8 | Received byte |
| fr_end | input | 1 | One-cycle strobe closing the frame |
| reg_addr | input | 6 | Register/byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after `reg_addr` |
| rdy_irq | output | 3 | Per-buffer ready interrupts |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is one where the age codes no longer follow the buffer indices. For example, buffer 2 may hold the oldest frame while buffer 0 holds the newest, and a release then lands in the middle of the age order. Directed steps do not get there in any natural order. The stimulus therefore mixes many random frames of 0 to 20 bytes with releases of random buffers, oldest-first drains and occasional mode flips. The random runs pass through full-queue overflow, mid-queue release and renumbering many times. Directed steps cover reset, single-buffer overflow, truncation, the all-release write and a frame sent while a release bit is held.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam logic [3:0] RA_ORDER = 4'h4;
  localparam logic [3:0] RA_CTRL  = 4'h5;
  localparam logic [3:0] RA_OVF   = 4'h6;
  localparam int unsigned MODE_BIT = 3;
endpackage

// File: rtl/frx_order_track.sv
module frx_order_track #(
  parameter int unsigned NBUF = 3,
  localparam int unsigned CW = $clog2(NBUF + 1),
  localparam int unsigned BW = $clog2(NBUF)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NBUF-1:0]      free_mask,
  input  logic                 alloc_en,
  input  logic [BW-1:0]        alloc_idx,
  output logic [NBUF*CW-1:0]   codes_o,
  output logic [NBUF-1:0]      busy_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] code_q [NBUF];
  logic [CW-1:0] code_d [NBUF];
  logic [NBUF-1:0] freed;
  logic [CW-1:0] occ, nfree, dec;

  always_comb begin
    occ   = '0;
    nfree = '0;
    dec   = '0;
    for (int i = 0; i < NBUF; i++) begin
      freed[i] = free_mask[i] && (code_q[i] != '0);
      if (code_q[i] != '0) occ = occ + ONE;
      if (freed[i]) nfree = nfree + ONE;
    end
    for (int i = 0; i < NBUF; i++) begin
      dec = '0;
      for (int j = 0; j < NBUF; j++)
        if (freed[j] && (code_q[j] < code_q[i])) dec = dec + ONE;
      if (freed[i])
        code_d[i] = '0;
      else if (code_q[i] != '0)
        code_d[i] = code_q[i] - dec;
      else if (alloc_en && (alloc_idx == BW'(i)))
        code_d[i] = occ - nfree + ONE;
      else
        code_d[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++) code_q[i] <= '0;
      busy_o <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        code_q[i] <= code_d[i];
        busy_o[i] <= (code_d[i] != '0);
      end
    end
  end

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_pack
      assign codes_o[g*CW +: CW] = code_q[g];
    end
  endgenerate
endmodule

// File: rtl/frx_capture.sv
module frx_capture #(
  parameter int unsigned NBUF  = 3,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned BW = $clog2(NBUF),
  localparam int unsigned OW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fr_start,
  input  logic            fr_valid,
  input  logic [7:0]      fr_byte,
  input  logic            fr_end,
  input  logic [NBUF-1:0] avail,
  output logic            wr_en,
  output logic [BW-1:0]   wr_buf,
  output logic [OW-1:0]   wr_ofs,
  output logic [7:0]      wr_data,
  output logic            done_en,
  output logic [BW-1:0]   done_buf,
  output logic [LW-1:0]   done_len,
  output logic            drop_pulse
);
  logic          active_q, discard_q;
  logic [BW-1:0] tgt_q;
  logic [LW-1:0] cnt_q;
  logic [BW-1:0] pick;
  logic          any_avail;

  always_comb begin
    pick      = '0;
    any_avail = 1'b0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (avail[i]) begin
        pick      = BW'(i);
        any_avail = 1'b1;
      end
    end
  end

  assign wr_en      = active_q && !discard_q && !fr_start && fr_valid && (cnt_q < LW'(DEPTH));
  assign wr_buf     = tgt_q;
  assign wr_ofs     = cnt_q[OW-1:0];
  assign wr_data    = fr_byte;
  assign done_en    = active_q && !discard_q && !fr_start && fr_end;
  assign done_buf   = tgt_q;
  assign done_len   = cnt_q + (wr_en ? LW'(1) : LW'(0));
  assign drop_pulse = fr_start && !any_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      discard_q <= 1'b0;
      tgt_q     <= '0;
      cnt_q     <= '0;
    end else if (fr_start) begin
      active_q  <= 1'b1;
      discard_q <= !any_avail;
      tgt_q     <= pick;
      cnt_q     <= '0;
    end else begin
      if (wr_en) cnt_q <= cnt_q + LW'(1);
      if (fr_end) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frx_store.sv
module frx_store #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/frame_rx_hub.sv
module frame_rx_hub
  import frx_pkg::*;
#(
  parameter int unsigned NBUF  = 3,
  parameter int unsigned DEPTH = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fr_start,
  input  logic                                   fr_valid,
  input  logic [7:0]                             fr_byte,
  input  logic                                   fr_end,
  input  logic [$clog2(NBUF)+$clog2(DEPTH)-1:0]  reg_addr,
  input  logic                                   reg_wr,
  input  logic [7:0]                             reg_wdata,
  output logic [7:0]                             reg_rdata,
  output logic [NBUF-1:0]                        rdy_irq,
  output logic                                   ovf_flag
);
  localparam int unsigned BW = $clog2(NBUF);
  localparam int unsigned OW = $clog2(DEPTH);
  localparam int unsigned AW = BW + OW;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned CW = $clog2(NBUF + 1);

  logic [NBUF-1:0]    hold_q;
  logic               mode_q;
  logic               ovf_q;
  logic [LW-1:0]      len_q [NBUF];
  logic [NBUF*LW-1:0] len_flat;
  logic [NBUF*CW-1:0] codes_w;
  logic [NBUF-1:0]    busy_w, avail_w, free_mask;
  logic               is_reg, ctrl_wr, commit;
  logic [OW-1:0]      reg_sel;

  logic               wr_en, done_en, drop_pulse;
  logic [BW-1:0]      wr_buf, done_buf;
  logic [OW-1:0]      wr_ofs;
  logic [7:0]         wr_data, mem_rd, reg_val, reg_val_q;
  logic [LW-1:0]      done_len;
  logic               is_reg_q;

  assign is_reg    = 32'(reg_addr[AW-1:OW]) >= NBUF;
  assign reg_sel   = reg_addr[OW-1:0];
  assign ctrl_wr   = reg_wr && is_reg && (reg_sel == OW'(RA_CTRL));
  assign free_mask = ctrl_wr ? (reg_wdata[NBUF-1:0] & ~hold_q) : '0;

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_avail
      if (g == 0) begin : g_first
        assign avail_w[g] = !busy_w[g] && !hold_q[g];
      end else begin : g_rest
        assign avail_w[g] = !busy_w[g] && !hold_q[g] && mode_q;
      end
      assign len_flat[g*LW +: LW] = len_q[g];
    end
  endgenerate

  assign commit = done_en && !hold_q[done_buf] && !free_mask[done_buf];

  frx_capture #(.NBUF(NBUF), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst(rst), .fr_start(fr_start), .fr_valid(fr_valid),
    .fr_byte(fr_byte), .fr_end(fr_end), .avail(avail_w),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_ofs(wr_ofs), .wr_data(wr_data),
    .done_en(done_en), .done_buf(done_buf), .done_len(done_len),
    .drop_pulse(drop_pulse)
  );

  frx_order_track #(.NBUF(NBUF)) u_ord (
    .clk(clk), .rst(rst), .free_mask(free_mask), .alloc_en(commit),
    .alloc_idx(done_buf), .codes_o(codes_w), .busy_o(busy_w)
  );

  frx_store #(.AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr({wr_buf, wr_ofs}), .wr_data(wr_data),
    .rd_addr(reg_addr), .rd_data(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
      for (int i = 0; i < NBUF; i++) len_q[i] <= '0;
    end else begin
      if (ctrl_wr) begin
        hold_q <= reg_wdata[NBUF-1:0];
        mode_q <= reg_wdata[MODE_BIT];
      end
      if (drop_pulse) ovf_q <= 1'b1;
      for (int i = 0; i < NBUF; i++) begin
        if (free_mask[i]) len_q[i] <= '0;
        else if (commit && (done_buf == BW'(i))) len_q[i] <= done_len;
      end
    end
  end

  always_comb begin
    reg_val = '0;
    if (reg_sel == OW'(RA_ORDER)) begin
      reg_val[NBUF*CW-1:0] = codes_w;
    end else if (reg_sel == OW'(RA_CTRL)) begin
      reg_val[NBUF-1:0] = hold_q;
      reg_val[MODE_BIT] = mode_q;
    end else if (reg_sel == OW'(RA_OVF)) begin
      reg_val[0] = ovf_q;
    end else if (32'(reg_sel) < NBUF) begin
      reg_val[LW-1:0] = len_q[reg_sel[BW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_val_q <= '0;
      is_reg_q  <= 1'b0;
    end else begin
      reg_val_q <= reg_val;
      is_reg_q  <= is_reg;
    end
  end

  assign reg_rdata = is_reg_q ? reg_val_q : mem_rd;
  assign rdy_irq   = busy_w;
  assign ovf_flag  = ovf_q;
endmodule

// File: rtl/frx_chk.sv
module frx_chk #(
  parameter int unsigned NBUF  = 3,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(NBUF + 1),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [NBUF*CW-1:0] codes,
  input logic [NBUF-1:0]    busy,
  input logic [NBUF-1:0]    hold,
  input logic               mode,
  input logic               ovf,
  input logic [NBUF*LW-1:0] lens
);
  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
      // R3
      code_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(codes[i*CW +: CW]) <= $countones(busy));
      // R5
      len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(lens[i*LW +: LW]) <= DEPTH);
      // R7
      held_empty_chk: assert property (@(posedge clk) disable iff (rst)
        hold[i] |-> (!busy[i] && (lens[i*LW +: LW] == '0)));
      if (i > 0) begin : g_upper
        // R8
        legacy_only_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(busy[i]) |-> $past(mode));
      end
      for (genvar j = i + 1; j < NBUF; j++) begin : g_pair
        // R3
        codes_distinct_chk: assert property (@(posedge clk) disable iff (rst)
          ((codes[i*CW +: CW] != '0) && (codes[j*CW +: CW] != '0))
            |-> (codes[i*CW +: CW] != codes[j*CW +: CW]));
      end
    end
  endgenerate

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind frame_rx_hub frx_chk #(.NBUF(NBUF), .DEPTH(DEPTH)) u_frx_chk (
  .clk(clk), .rst(rst), .codes(codes_w), .busy(rdy_irq), .hold(hold_q),
  .mode(mode_q), .ovf(ovf_flag), .lens(len_flat)
);

// File: tb/frame_rx_hub_bench.sv
`timescale 1ns/1ps
module frame_rx_hub_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fr_start = 1'b0, fr_valid = 1'b0, fr_end = 1'b0;
  logic [7:0] fr_byte = '0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] rdy_irq;
  logic       ovf_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int         m_code [3];
  int         m_len  [3];
  logic [7:0] m_dat  [3][16];
  bit         m_hold [3];
  bit         m_mode;
  bit         m_ovf;

  always #10 clk = ~clk;

  frame_rx_hub u_frame_rx_hub (
    .clk(clk), .rst(rst), .fr_start(fr_start), .fr_valid(fr_valid),
    .fr_byte(fr_byte), .fr_end(fr_end), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rdy_irq(rdy_irq),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int exp_status();
    return m_code[0] | (m_code[1] << 2) | (m_code[2] << 4);
  endfunction

  function automatic int exp_irq();
    int v = 0;
    for (int i = 0; i < 3; i++) if (m_code[i] != 0) v |= (1 << i);
    return v;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 3; i++) begin
      m_code[i] = 0; m_len[i] = 0; m_hold[i] = 0;
    end
    m_mode = 0; m_ovf = 0;
  endfunction

  function automatic void m_free(input int mask);
    int nc [3];
    for (int i = 0; i < 3; i++) begin
      int d = 0;
      if (((mask >> i) & 1) != 0) begin
        nc[i] = 0;
      end else begin
        for (int j = 0; j < 3; j++)
          if ((((mask >> j) & 1) != 0) && m_code[j] != 0 && m_code[j] < m_code[i]) d++;
        nc[i] = (m_code[i] != 0) ? m_code[i] - d : 0;
      end
    end
    for (int i = 0; i < 3; i++) begin
      if (((mask >> i) & 1) != 0) m_len[i] = 0;
      m_code[i] = nc[i];
    end
  endfunction

  task automatic reset_dut();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_ctrl(input int v);
    int newly = v & 7 & ~((m_hold[0] ? 1 : 0) | (m_hold[1] ? 2 : 0) | (m_hold[2] ? 4 : 0));
    wr(6'h35, 8'(v));
    m_free(newly);
    for (int i = 0; i < 3; i++) m_hold[i] = ((v >> i) & 1) != 0;
    m_mode = ((v >> 3) & 1) != 0;
  endtask

  task automatic send(input int n);
    logic [7:0] fb [32];
    int tgt = -1;
    for (int k = 0; k < n; k++) fb[k] = 8'($urandom);
    @(negedge clk);
    fr_start = 1'b1;
    @(negedge clk);
    fr_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      fr_valid = 1'b1; fr_byte = fb[k];
      @(negedge clk);
    end
    fr_valid = 1'b0; fr_end = 1'b1;
    @(negedge clk);
    fr_end = 1'b0;
    for (int i = 2; i >= 0; i--)
      if (m_code[i] == 0 && !m_hold[i] && (m_mode || i == 0)) tgt = i;
    if (tgt < 0) begin
      m_ovf = 1;
    end else begin
      int occ = 0;
      for (int i = 0; i < 3; i++) if (m_code[i] != 0) occ++;
      m_code[tgt] = occ + 1;
      m_len[tgt] = (n > 16) ? 16 : n;
      for (int k = 0; k < 16 && k < n; k++) m_dat[tgt][k] = fb[k];
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    rd(6'h34, d);
    chk({req, " R3 order status"}, int'(d), exp_status());
    chk({req, " R6 ready irq"}, int'(rdy_irq), exp_irq());
    chk({req, " R9 ovf flag"}, int'(ovf_flag), int'(m_ovf));
    for (int i = 0; i < 3; i++) begin
      rd(6'(6'h30 + i), d);
      chk({req, " R5 length"}, int'(d[4:0]), m_len[i]);
    end
  endtask

  task automatic check_data(input int b, input string req);
    logic [7:0] d;
    for (int k = 0; k < m_len[b]; k++) begin
      rd(6'(b * 16 + k), d);
      chk({req, " R2 data"}, int'(d), int'(m_dat[b][k]));
    end
  endtask

  task automatic release_buf(input int b);
    int base = m_mode ? 8 : 0;
    set_ctrl(base | (1 << b));
    chk("R7 held buffer irq low", int'(rdy_irq[b]), 0);
    set_ctrl(base);
  endtask

  task automatic drain_oldest();
    for (int i = 0; i < 3; i++) begin
      if (m_code[i] == 1) begin
        check_data(i, "R3 oldest");
        release_buf(i);
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    m_reset();
    reset_dut();

    // R1 reset state
    check_all("R1");
    rd(6'h35, d);
    chk("R1 control reset", int'(d), 0);
    chk("R1 irq reset", int'(rdy_irq), 0);

    // R8 single-buffer mode, R9 overflow
    send(3);
    check_all("R8 legacy first");
    chk("R8 buffer0 used", m_code[0], 1);
    send(4);
    chk("R9 ovf set in legacy", int'(ovf_flag), 1);
    check_all("R9 legacy overflow");
    check_data(0, "R9 buffer0 untouched");
    rd(6'h36, d);
    chk("R9 ovf register", int'(d[0]), 1);

    reset_dut();
    chk("R1 ovf cleared by reset", int'(ovf_flag), 0);
    set_ctrl(8'h08);

    // R4, R5 fill three buffers, truncation
    send(5);
    send(16);
    send(20);
    check_all("R4 three frames");
    chk("R4 newest code", m_code[2], 3);
    chk("R5 truncated length", m_len[2], 16);
    check_data(2, "R5 truncated");
    check_data(1, "R2 full frame");

    // R9 overflow with all three full
    send(2);
    check_all("R9 full overflow");

    // R7 release middle
    release_buf(1);
    check_all("R7 middle release");
    send(7);
    check_all("R4 refill lowest");
    check_data(1, "R2 refill");

    // R8 release everything
    set_ctrl(8'h0F);
    check_all("R8 clear all");
    rd(6'h35, d);
    chk("R8 mode kept", int'(d[3]), 1);
    set_ctrl(8'h08);

    // R7 held buffer not used
    set_ctrl(8'h09);
    send(3);
    check_all("R7 held skip");
    chk("R7 frame in buffer1", m_code[1], 1);
    set_ctrl(8'h08);
    send(2);
    check_all("R7 reuse after clear");
    chk("R7 buffer0 reused", m_code[0], 2);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 19);
      if (r < 9) send($urandom_range(0, 20));
      else if (r < 13) drain_oldest();
      else if (r < 17) release_buf($urandom_range(0, 2));
      else if (r == 17) set_ctrl(m_mode ? 0 : 8);
      else begin
        for (int i = 0; i < 3; i++) if (m_code[i] != 0) check_data(i, "R2 random");
      end
      check_all("R4 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule